// File: doc/BRIEF.md
# Push-Multiple Stack Sequencer

This block carries out a single push-multiple instruction. It receives the opcode byte, an 8-bit register-select mask and the current stack pointer. It then stores each chosen register to memory as one 32-bit word. Each register has a fixed slot below the incoming stack pointer. Slot k (k = 1 for the first slot) sits at SP - 4k, and a register keeps its slot even when the registers around it are not chosen. The stores run one at a time through a valid/ready write port. The block reads each register's value through a register-file read port that it addresses by register index.

When the last store has completed, the block lowers the stack pointer. A selected register group lowers it by a fixed 48-byte frame. Otherwise it lowers it to the lowest written slot. The new value appears together with a one-cycle done pulse. If the mask selects nothing, the instruction finishes at once without touching memory.

Top module: `push_multiple_seq`

## Requirements
- R1: A start request is accepted only when the block is idle and `op` equals 0xCF. A request with any other opcode causes no store and no done pulse.
- R2: The register index driven on `rf_idx` uses this code: D0=0, D1=1, D2=2, D3=3, A0=4, A1=5, A2=6, A3=7, MDR=8, LIR=9, LAR=10. The slots are numbered 1 to 11 and hold these registers in this order: D2, D3, A2, A3, D0, D1, A0, A1, MDR, LIR, LAR. Slot k is stored at `sp_in - 4*k`, and the store data is `rf_data` for that register.
- R3: Selected registers are stored in ascending slot order, one store per accepted handshake.
- R4: The mask bits select as follows: bit 7 selects D2, bit 6 D3, bit 5 A2 and bit 4 A3. Bit 3 selects the whole group D0, D1, A0, A1, MDR, LIR and LAR. Bits 2 to 0 are ignored.
- R5: An unselected register produces no memory cycle and does not shift the slot address of any other register.
- R6: `mem_valid`, `mem_addr` and `rf_idx` stay stable until `mem_ready` is sampled high. The next store is presented in the following cycle, so with `mem_ready` held high, n stores finish with done n+1 cycles after the start edge.
- R7: When mask bit 3 is set, the new stack pointer is `sp_in - 48`.
- R8: When mask bit 3 is clear and at least one register is selected, the new stack pointer is `sp_in - 4*k`, where k is the highest slot written.
- R9: When mask bits 7 to 3 are all zero, `done` pulses one cycle after the start edge with no store and with `sp_we` low.
- R10: `done` is a single-cycle pulse in the cycle after the final handshake. In that cycle `sp_we` is high and `sp_out` holds the new stack pointer.
- R11: A start request that arrives while stores are pending has no effect on the running instruction.
- R12: After reset, `mem_valid`, `busy`, `done` and `sp_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to execute the presented instruction |
| op | input | 8 | Opcode byte |
| mask | input | 8 | Register-select mask byte |
| sp_in | input | 32 | Stack pointer at instruction start |
| rf_idx | output | 4 | Register-file read index |
| rf_data | input | 32 | Register-file read data for `rf_idx` |
| mem_valid | output | 1 | Store request valid |
| mem_addr | output | 32 | Store byte address |
| mem_data | output | 32 | Store data |
| mem_ready | input | 1 | Memory accepts the store |
| busy | output | 1 | Stores are pending |
| done | output | 1 | One-cycle completion pulse |
| sp_we | output | 1 | New stack pointer valid |
| sp_out | output | 32 | New stack pointer |

## Verification
The hardest situation to reach from the ports is a second start request that lands while a sparse, stalled sequence is still in flight. Another hard case is a pending store held across several cycles in which `mem_ready` is low. The bench drives a memory model that grants `mem_ready` only one cycle in three. While that model is stalling, the bench raises a second start with a different mask and stack pointer. It then checks that the logged stores, the single done pulse and the final stack pointer all belong to the first instruction. The mask set includes gapped masks, a mask with only the reserved bits set, and a wrong opcode. Together these cover slot preservation and the zero-work path.

// File: rtl/push_seq_pkg.sv
package push_seq_pkg;
  localparam int N_SLOTS     = 11;
  localparam int SLOT_W      = $clog2(N_SLOTS);
  localparam int REG_IDX_W   = 4;
  localparam int SOLO_SLOTS  = 4;
  localparam int GROUP_BIT   = 3;
  localparam int FRAME_WORDS = 12;

  // Register index held in each slot; slot 0 sits one word below SP.
  function automatic logic [REG_IDX_W-1:0] slot_reg(input logic [SLOT_W-1:0] s);
    case (s)
      4'd0:    slot_reg = 4'd2;
      4'd1:    slot_reg = 4'd3;
      4'd2:    slot_reg = 4'd6;
      4'd3:    slot_reg = 4'd7;
      4'd4:    slot_reg = 4'd0;
      4'd5:    slot_reg = 4'd1;
      4'd6:    slot_reg = 4'd4;
      4'd7:    slot_reg = 4'd5;
      4'd8:    slot_reg = 4'd8;
      4'd9:    slot_reg = 4'd9;
      default: slot_reg = 4'd10;
    endcase
  endfunction
endpackage

// File: rtl/push_mask_decode.sv
module push_mask_decode #(
  parameter int MASK_W      = 8,
  parameter int N_SLOTS     = 11,
  parameter int SOLO_SLOTS  = 4,
  parameter int GROUP_BIT   = 3,
  parameter int ADDR_W      = 32,
  parameter int WORD_BYTES  = 4,
  parameter int FRAME_WORDS = 12
) (
  input  logic [MASK_W-1:0]  mask,
  output logic [N_SLOTS-1:0] sel,
  output logic [ADDR_W-1:0]  frame
);
  // R4: solo slots follow the top mask bits, the rest follow the group bit
  for (genvar i = 0; i < N_SLOTS; i++) begin : g_sel
    if (i < SOLO_SLOTS) begin : g_solo
      assign sel[i] = mask[MASK_W-1-i];
    end else begin : g_grp
      assign sel[i] = mask[GROUP_BIT];
    end
  end

  logic unused_reserved;
  assign unused_reserved = ^mask[GROUP_BIT-1:0];

  // R7/R8: fixed frame with the group, otherwise down to the lowest solo slot
  always_comb begin
    frame = '0;
    for (int i = 0; i < SOLO_SLOTS; i++)
      if (sel[i]) frame = ADDR_W'(WORD_BYTES * (i + 1));
    if (mask[GROUP_BIT]) frame = ADDR_W'(WORD_BYTES * FRAME_WORDS);
  end
endmodule

// File: rtl/push_slot_pick.sv
module push_slot_pick #(
  parameter int N_SLOTS = 11,
  parameter int SLOT_W  = $clog2(N_SLOTS)
) (
  input  logic [N_SLOTS-1:0] pend,
  output logic [SLOT_W-1:0]  idx
);
  // lowest pending slot wins (R3 ascending order)
  always_comb begin
    idx = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--)
      if (pend[i]) idx = SLOT_W'(i);
  end
endmodule

// File: rtl/push_multiple_seq.sv
module push_multiple_seq
  import push_seq_pkg::*;
#(
  parameter int          DATA_W     = 32,
  parameter int          ADDR_W     = 32,
  parameter int          MASK_W     = 8,
  parameter int          WORD_BYTES = 4,
  parameter logic [7:0]  OPCODE     = 8'hCF
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [7:0]           op,
  input  logic [MASK_W-1:0]    mask,
  input  logic [ADDR_W-1:0]    sp_in,
  output logic [REG_IDX_W-1:0] rf_idx,
  input  logic [DATA_W-1:0]    rf_data,
  output logic                 mem_valid,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_data,
  input  logic                 mem_ready,
  output logic                 busy,
  output logic                 done,
  output logic                 sp_we,
  output logic [ADDR_W-1:0]    sp_out
);
  logic [N_SLOTS-1:0] sel, pend_q, pend_nx, clr;
  logic [ADDR_W-1:0]  frame, base_q, sp_new_q, sp_out_q;
  logic [SLOT_W-1:0]  cur;
  logic               done_q, sp_we_q, accept, fire;

  push_mask_decode #(
    .MASK_W(MASK_W), .N_SLOTS(N_SLOTS), .SOLO_SLOTS(SOLO_SLOTS),
    .GROUP_BIT(GROUP_BIT), .ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES),
    .FRAME_WORDS(FRAME_WORDS)
  ) u_dec (.mask(mask), .sel(sel), .frame(frame));

  push_slot_pick #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_pick (.pend(pend_q), .idx(cur));

  // R1/R11: accept only when idle and opcode matches
  assign accept  = start && (op == OPCODE) && (pend_q == '0);
  assign fire    = mem_valid && mem_ready;
  assign clr     = fire ? (N_SLOTS'(1) << cur) : '0;
  assign pend_nx = pend_q & ~clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= '0;
      base_q   <= '0;
      sp_new_q <= '0;
      sp_out_q <= '0;
      done_q   <= 1'b0;
      sp_we_q  <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      sp_we_q <= 1'b0;
      if (accept) begin
        pend_q   <= sel;
        base_q   <= sp_in;
        sp_new_q <= sp_in - frame;
        if (sel == '0) done_q <= 1'b1;      // R9
      end else if (fire) begin
        pend_q <= pend_nx;
        if (pend_nx == '0) begin            // R10
          done_q   <= 1'b1;
          sp_we_q  <= 1'b1;
          sp_out_q <= sp_new_q;
        end
      end
    end
  end

  // R2: slot address and register index
  assign mem_valid = |pend_q;
  assign busy      = mem_valid;
  assign rf_idx    = slot_reg(cur);
  assign mem_addr  = base_q - ADDR_W'(WORD_BYTES * (int'(cur) + 1));
  assign mem_data  = rf_data;
  assign done      = done_q;
  assign sp_we     = sp_we_q;
  assign sp_out    = sp_out_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(rf_idx));

  assert_order_R3: assert property (@(posedge clk) disable iff (rst)
    fire && ($countones(pend_q) > 1) |=> mem_valid && (cur > $past(cur)));

  assert_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_spwe_R10: assert property (@(posedge clk) disable iff (rst)
    sp_we |-> done);

  assert_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_valid);

  assert_keep_R11: assert property (@(posedge clk) disable iff (rst)
    mem_valid |=> $stable(base_q) && $stable(sp_new_q));
endmodule

// File: tb/push_multiple_seq_bench.sv
module push_multiple_seq_bench;
  logic        clk = 1'b0;
  logic        rst, start, mem_ready, mem_valid, busy, done, sp_we;
  logic [7:0]  op, mask;
  logic [31:0] sp_in, rf_data, mem_addr, mem_data, sp_out;
  logic [3:0]  rf_idx;

  always #5 clk = ~clk;

  push_multiple_seq u_push_multiple_seq (
    .clk(clk), .rst(rst), .start(start), .op(op), .mask(mask), .sp_in(sp_in),
    .rf_idx(rf_idx), .rf_data(rf_data), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ready(mem_ready), .busy(busy), .done(done),
    .sp_we(sp_we), .sp_out(sp_out));

  assign rf_data = 32'h5A00_0000 | {28'h0, rf_idx};

  int n_chk = 0, n_bad = 0, cyc = 0, rc = 0;
  int nw, n_done, hold_err, start_cyc, done_cyc;
  logic stall = 1'b0, hold_pend = 1'b0, spwe_seen;
  logic [31:0] hold_addr, sp_seen;
  logic [31:0] log_a [16];
  logic [31:0] log_d [16];
  logic [3:0]  exp_reg [11];

  initial begin
    exp_reg[0] = 2; exp_reg[1] = 3; exp_reg[2] = 6; exp_reg[3]  = 7;
    exp_reg[4] = 0; exp_reg[5] = 1; exp_reg[6] = 4; exp_reg[7]  = 5;
    exp_reg[8] = 8; exp_reg[9] = 9; exp_reg[10] = 10;
  end

  always @(negedge clk) begin
    rc = rc + 1;
    mem_ready = stall ? (rc % 3 == 2) : 1'b1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      if (hold_pend && (!mem_valid || mem_addr != hold_addr)) hold_err++;
      hold_pend = mem_valid && !mem_ready;
      hold_addr = mem_addr;
      if (mem_valid && mem_ready && nw < 16) begin
        log_a[nw] = mem_addr; log_d[nw] = mem_data; nw++;
      end
      if (start && !busy && op == 8'hCF) start_cyc = cyc;
      if (done) begin n_done++; done_cyc = cyc; spwe_seen = sp_we; sp_seen = sp_out; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit selb(input logic [7:0] m, input int k);
    return (k < 4) ? m[7-k] : m[3];
  endfunction

  task automatic clear_log();
    nw = 0; n_done = 0; hold_err = 0; spwe_seen = 1'b0; done_cyc = -100; start_cyc = 0;
  endtask

  task automatic run_push(input logic [7:0] m, input logic [31:0] sp,
                          input bit stl, input bit intrude);
    int ne = 0, hi = 0;
    logic [31:0] exp_sp;
    clear_log();
    stall = stl;
    @(negedge clk); op = 8'hCF; mask = m; sp_in = sp; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (intrude) begin
      repeat (2) @(negedge clk);
      mask = 8'h08; sp_in = 32'hDEAD_0000; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int w = 0; w < 200 && n_done == 0; w++) @(negedge clk);
    repeat (3) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      if (selb(m, k)) begin
        if (ne < nw) begin
          chk(log_a[ne] == sp - 32'(4 * (k + 1)), "R2/R3/R5", "store addr", log_a[ne], sp - 32'(4 * (k + 1)));
          chk(log_d[ne] == (32'h5A00_0000 | {28'h0, exp_reg[k]}), "R2", "store data",
              log_d[ne], 32'h5A00_0000 | {28'h0, exp_reg[k]});
        end
        ne++; hi = k + 1;
      end
    end
    chk(nw == ne, intrude ? "R11" : "R4/R5", "store count", nw, ne);
    chk(n_done == 1, "R10", "done pulses", n_done, 1);
    chk(hold_err == 0, "R6", "hold violations", hold_err, 0);
    if (ne == 0) begin
      chk(spwe_seen == 1'b0, "R9", "sp_we on empty mask", {31'b0, spwe_seen}, 0);
      chk(done_cyc == start_cyc + 1, "R9", "empty done latency", done_cyc - start_cyc, 1);
    end else begin
      exp_sp = m[3] ? sp - 32'd48 : sp - 32'(4 * hi);
      chk(spwe_seen == 1'b1, "R10", "sp_we at done", {31'b0, spwe_seen}, 1);
      chk(sp_seen == exp_sp, m[3] ? "R7" : "R8", "new sp", sp_seen, exp_sp);
      if (!stl) chk(done_cyc == start_cyc + ne + 1, "R6", "done latency", done_cyc - start_cyc, ne + 1);
    end
    stall = 1'b0;
  endtask

  task automatic run_bad_op();
    clear_log();
    @(negedge clk); op = 8'hCE; mask = 8'hFF; sp_in = 32'h3000; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (20) @(negedge clk);
    chk(nw == 0, "R1", "stores on wrong opcode", nw, 0);
    chk(n_done == 0, "R1", "done on wrong opcode", n_done, 0);
  endtask

  task automatic run_reset();
    rst = 1'b1; start = 1'b0; op = 8'h00; mask = 8'h00; sp_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!mem_valid && !busy, "R12", "valid/busy after reset", {30'b0, mem_valid, busy}, 0);
    chk(!done && !sp_we, "R12", "done/sp_we after reset", {30'b0, done, sp_we}, 0);
  endtask

  initial begin
    run_reset();
    run_push(8'hF8, 32'h0000_1000, 1'b0, 1'b0);
    run_push(8'h80, 32'h0000_2000, 1'b0, 1'b0);
    run_push(8'h50, 32'h0000_4000, 1'b0, 1'b0);
    run_push(8'h08, 32'h0000_8000, 1'b0, 1'b0);
    run_push(8'h07, 32'h0000_5000, 1'b0, 1'b0);
    run_push(8'h00, 32'h0000_6000, 1'b0, 1'b0);
    run_push(8'hA8, 32'h0001_0000, 1'b1, 1'b0);
    run_push(8'h60, 32'h0000_0040, 1'b0, 1'b0);
    run_bad_op();
    run_push(8'hB0, 32'h0002_0000, 1'b1, 1'b1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule